// File: doc/BRIEF.md
# Key-protected watchdog timer

This block is a watchdog timer for the always-on part of a chip. A low-frequency tick, made outside the block, drives a 31-bit up-counter. A 4-bit scale field selects how far the count is shifted right. The low 16 bits of the shifted value form the scaled count, which is compared against a 16-bit threshold. When the scaled count reaches or passes the threshold, the block sets a sticky pending flag, which drives the interrupt output. It can also send a one-cycle reset request to the system, and it can clear the counter automatically.

Software reaches the block through a 32-bit register port. A one-shot unlock word protects every write to the configuration, count, restart and threshold registers. A separate magic word, written to the restart register, clears the counter.

The request side is a valid/ready channel. `req_ready_o` is always high, so the block never applies back-pressure and takes one request in every cycle that `req_valid_o` is high. The response side has no ready: every accepted read returns `rsp_valid_o` with its data one cycle later, and the host must take it in that cycle.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the configuration register reads 0, the threshold reads 0x0000BEEF and the key register reads 0. Both `irq_o` and `rst_req_o` are low.
- R2: Writing exactly 0x0051F15E to the key register (offset 0x1C) sets the unlock flag. A key write of any other value leaves the flag unchanged. A key read returns the flag in bit 0, with all other bits 0.
- R3: While the block is locked, writes to configuration (0x00), count (0x08), restart (0x18) and threshold (0x20) have no effect. An accepted write to any of these four registers clears the unlock flag. A write to the scaled-count register (0x10) changes nothing and does not relock the block.
- R4: An unlocked write of 0x0D09F00D to the restart register (0x18) clears the counter. Any other value leaves the counter unchanged but still relocks the block. Reads of 0x18 return 0.
- R5: The counter is 31 bits wide. A count write loads write-data bits 30:0, and bit 31 of a count read is always 0.
- R6: The counter increases by one on each clock edge where `tick_i` is high, provided that configuration bit 12 is set, or that bit 13 is set and `core_awake_i` is high. Otherwise it holds its value.
- R7: The scaled-count register (0x10) reads the count shifted right by configuration bits 3:0, truncated to 16 bits, with zeros in the upper half.
- R8: When the scaled count is greater than or equal to the threshold, pending bit 28 of the configuration register is set one edge later, and `irq_o` follows it. The flag stays set until an unlocked configuration write has bit 28 low.
- R9: When configuration bit 8 is set, `rst_req_o` is high for exactly one cycle after the first cycle of each match. When bit 8 is clear, it stays low.
- R10: When configuration bit 9 is set, a match clears the counter on the next edge.
- R11: A read request returns `rsp_valid_o` high with its data one cycle later. Configuration reads place the scale in bits 3:0 and the flags in bits 8, 9, 12, 13 and 28, with 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready, always 1 |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata_o | output | 32 | Read data |
| tick_i | input | 1 | Low-frequency count tick, one clock wide per tick |
| core_awake_i | input | 1 | High while the core is awake |
| irq_o | output | 1 | Interrupt, follows the pending flag |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The counting function is driven with three tick patterns: a continuous burst, an alternating on/off pattern, and bursts with the awake input high and then low under the awake-only enable. The final counts show whether single ticks are missed and whether the enable gating works. Compare events are run with and without reset enable over a window long enough for two matches with auto-zero. This separates the one-cycle pulse from a level or repeated pulse and shows that the counter wraps at the threshold. The key and restart sequences use exact, off-by-one and wrong words, and check after each write that the relock behaves as required.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SHIFT_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_SCL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_FEED = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_KEY  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CMP  = 8'h20;

  localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h0051_F15E;
  localparam logic [DATA_W-1:0] FEED_WORD   = 32'h0D09_F00D;

  localparam int unsigned B_RSTEN = 8;
  localparam int unsigned B_ZCMP  = 9;
  localparam int unsigned B_ENA   = 12;
  localparam int unsigned B_ENW   = 13;
  localparam int unsigned B_PEND  = 28;

  typedef struct packed {
    logic [SHIFT_W-1:0] scale;
    logic               rst_en;
    logic               zero_cmp;
    logic               en_always;
    logic               en_awake;
  } cfg_t;
endpackage

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned CNT_W     = 31,
  parameter int unsigned CMP_W     = 16,
  parameter logic [15:0] CMP_RESET = 16'hBEEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CMP_W-1:0]  scaled_i,
  input  logic              pend_i,
  output cfg_t              cfg_o,
  output logic [CMP_W-1:0]  cmp_o,
  output logic              cfg_wr_o,
  output logic              cfg_pend_o,
  output logic              cnt_wr_o,
  output logic [CNT_W-1:0]  cnt_wdata_o,
  output logic              feed_o
);
  logic wr, guarded, accept, unlock_q;
  logic [DATA_W-1:0] rd_data;

  assign wr      = req_valid_i && req_we_i;
  assign guarded = (req_addr_i == OFF_CFG) || (req_addr_i == OFF_CNT) ||
                   (req_addr_i == OFF_FEED) || (req_addr_i == OFF_CMP);
  assign accept  = wr && guarded && unlock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlock_q <= 1'b0;
    end else if (accept) begin
      unlock_q <= 1'b0;
    end else if (wr && req_addr_i == OFF_KEY && req_wdata_i == UNLOCK_WORD) begin
      unlock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
      cmp_o <= CMP_W'(CMP_RESET);
    end else begin
      if (accept && req_addr_i == OFF_CFG) begin
        cfg_o.scale     <= req_wdata_i[SHIFT_W-1:0];
        cfg_o.rst_en    <= req_wdata_i[B_RSTEN];
        cfg_o.zero_cmp  <= req_wdata_i[B_ZCMP];
        cfg_o.en_always <= req_wdata_i[B_ENA];
        cfg_o.en_awake  <= req_wdata_i[B_ENW];
      end
      if (accept && req_addr_i == OFF_CMP) cmp_o <= req_wdata_i[CMP_W-1:0];
    end
  end

  assign cfg_wr_o    = accept && req_addr_i == OFF_CFG;
  assign cfg_pend_o  = req_wdata_i[B_PEND];
  assign cnt_wr_o    = accept && req_addr_i == OFF_CNT;
  assign cnt_wdata_o = req_wdata_i[CNT_W-1:0];
  assign feed_o      = accept && req_addr_i == OFF_FEED && req_wdata_i == FEED_WORD;

  always_comb begin
    rd_data = '0;
    case (req_addr_i)
      OFF_CFG: begin
        rd_data[SHIFT_W-1:0] = cfg_o.scale;
        rd_data[B_RSTEN]     = cfg_o.rst_en;
        rd_data[B_ZCMP]      = cfg_o.zero_cmp;
        rd_data[B_ENA]       = cfg_o.en_always;
        rd_data[B_ENW]       = cfg_o.en_awake;
        rd_data[B_PEND]      = pend_i;
      end
      OFF_CNT: rd_data[CNT_W-1:0] = cnt_i;
      OFF_SCL: rd_data[CMP_W-1:0] = scaled_i;
      OFF_KEY: rd_data[0]         = unlock_q;
      OFF_CMP: rd_data[CMP_W-1:0] = cmp_o;
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && !req_we_i;
      if (req_valid_i && !req_we_i) rsp_rdata_o <= rd_data;
    end
  end

  p_locked_cmp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == OFF_CMP && !unlock_q) |=> $stable(cmp_o));
  p_relock_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !unlock_q);
  p_rsp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i) |=> rsp_valid_o);
endmodule

// File: rtl/wdt_keyed_core.sv
module wdt_keyed_core
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned CNT_W = 31,
  parameter int unsigned CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             core_awake_i,
  input  cfg_t             cfg_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_pend_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  input  logic             feed_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CMP_W-1:0] scaled_o,
  output logic             pend_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] shifted;
  logic run, match, match_q, auto_zero;

  assign shifted   = cnt_o >> cfg_i.scale;
  assign scaled_o  = shifted[CMP_W-1:0];
  assign match     = scaled_o >= cmp_i;
  assign run       = cfg_i.en_always || (cfg_i.en_awake && core_awake_i);
  assign auto_zero = match && cfg_i.zero_cmp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (cnt_wr_i) begin
      cnt_o <= cnt_wdata_i;
    end else if (feed_i || auto_zero) begin
      cnt_o <= '0;
    end else if (run && tick_i) begin
      cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o    <= 1'b0;
      match_q   <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      if (match)         pend_o <= 1'b1;
      else if (cfg_wr_i) pend_o <= cfg_pend_i;
      match_q   <= match;
      rst_req_o <= match && !match_q && cfg_i.rst_en;
    end
  end

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run && tick_i) && !cnt_wr_i && !feed_i && !auto_zero) |=> $stable(cnt_o));
  p_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_zero && !cnt_wr_i) |=> (cnt_o == '0));
  p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> pend_o);
  p_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned CNT_W     = 31,
  parameter int unsigned CMP_W     = 16,
  parameter logic [15:0] CMP_RESET = 16'hBEEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              tick_i,
  input  logic              core_awake_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  cfg_t             cfg;
  logic [CMP_W-1:0] cmp, scaled;
  logic [CNT_W-1:0] cnt, cnt_wdata;
  logic             cfg_wr, cfg_pend, cnt_wr, feed, pend;

  assign req_ready_o = 1'b1;
  assign irq_o       = pend;

  wdt_keyed_regs #(.CNT_W(CNT_W), .CMP_W(CMP_W), .CMP_RESET(CMP_RESET)) u_regs (
    .clk_i, .rst_ni, .req_valid_i, .req_we_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_rdata_o,
    .cnt_i(cnt), .scaled_i(scaled), .pend_i(pend),
    .cfg_o(cfg), .cmp_o(cmp), .cfg_wr_o(cfg_wr), .cfg_pend_o(cfg_pend),
    .cnt_wr_o(cnt_wr), .cnt_wdata_o(cnt_wdata), .feed_o(feed)
  );

  wdt_keyed_core #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_core (
    .clk_i, .rst_ni, .tick_i, .core_awake_i,
    .cfg_i(cfg), .cmp_i(cmp), .cfg_wr_i(cfg_wr), .cfg_pend_i(cfg_pend),
    .cnt_wr_i(cnt_wr), .cnt_wdata_i(cnt_wdata), .feed_i(feed),
    .cnt_o(cnt), .scaled_o(scaled), .pend_o(pend), .rst_req_o(rst_req_o)
  );
endmodule

// File: tb/wdt_keyed_tb_top.sv
`timescale 1ns/1ps
module wdt_keyed_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, tick = 1'b0, awake = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, irq, rst_req;
  logic [31:0] rsp_rdata;
  int n_chk = 0, n_fail = 0, pulses = 0, doubles = 0;
  logic prev_req = 1'b0;

  always #4 clk = ~clk;

  wdt_keyed dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .tick_i(tick),
    .core_awake_i(awake), .irq_o(irq), .rst_req_o(rst_req)
  );

  always @(negedge clk) begin
    if (rst_req) pulses++;
    if (rst_req && prev_req) doubles++;
    prev_req = rst_req;
  end

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam logic [31:0] KEY = 32'h0051F15E;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0,          32'h0,          4'd1},  // R1 config reset
    '{1'b0, 8'h20, 32'h0,          32'h0000BEEF,   4'd1},  // R1 threshold reset
    '{1'b0, 8'h1C, 32'h0,          32'h0,          4'd1},  // R1 locked
    '{1'b1, 8'h20, 32'h1234,       32'h0,          4'd3},
    '{1'b0, 8'h20, 32'h0,          32'h0000BEEF,   4'd3},  // R3 locked write ignored
    '{1'b1, 8'h1C, KEY,            32'h0,          4'd2},
    '{1'b0, 8'h1C, 32'h0,          32'h1,          4'd2},  // R2 unlocked
    '{1'b1, 8'h20, 32'h1234,       32'h0,          4'd3},
    '{1'b0, 8'h20, 32'h0,          32'h1234,       4'd3},  // R3 accepted
    '{1'b0, 8'h1C, 32'h0,          32'h0,          4'd3},  // R3 relocked
    '{1'b1, 8'h1C, 32'h0051F15F,   32'h0,          4'd2},
    '{1'b0, 8'h1C, 32'h0,          32'h0,          4'd2},  // R2 wrong key
    '{1'b1, 8'h1C, KEY,            32'h0,          4'd5},
    '{1'b1, 8'h08, 32'hFFFFFFFF,   32'h0,          4'd5},
    '{1'b0, 8'h08, 32'h0,          32'h7FFFFFFF,   4'd5},  // R5 bit31 zero
    '{1'b0, 8'h10, 32'h0,          32'h0000FFFF,   4'd7},  // R7 truncation
    '{1'b0, 8'h00, 32'h0,          32'h10000000,   4'd8},  // R8 pending set
    '{1'b1, 8'h1C, KEY,            32'h0,          4'd3},
    '{1'b1, 8'h10, 32'h5,          32'h0,          4'd3},
    '{1'b0, 8'h1C, 32'h0,          32'h1,          4'd3},  // R3 scaled write keeps unlock
    '{1'b1, 8'h18, 32'h12345678,   32'h0,          4'd4},
    '{1'b0, 8'h08, 32'h0,          32'h7FFFFFFF,   4'd4},  // R4 wrong feed
    '{1'b0, 8'h1C, 32'h0,          32'h0,          4'd4},  // R4 wrong feed relocks
    '{1'b1, 8'h1C, KEY,            32'h0,          4'd4},
    '{1'b1, 8'h18, 32'h0D09F00D,   32'h0,          4'd4},
    '{1'b0, 8'h08, 32'h0,          32'h0,          4'd4},  // R4 feed clears
    '{1'b0, 8'h18, 32'h0,          32'h0,          4'd4},  // R4 feed reads 0
    '{1'b0, 8'h00, 32'h0,          32'h10000000,   4'd8},  // R8 sticky
    '{1'b1, 8'h1C, KEY,            32'h0,          4'd8},
    '{1'b1, 8'h00, 32'h00000003,   32'h0,          4'd8},
    '{1'b0, 8'h00, 32'h0,          32'h00000003,   4'd8},  // R8 cleared, R11 layout
    '{1'b1, 8'h1C, KEY,            32'h0,          4'd7},
    '{1'b1, 8'h08, 32'h00000100,   32'h0,          4'd7},
    '{1'b0, 8'h10, 32'h0,          32'h00000020,   4'd7},  // R7 shift by 3
    '{1'b1, 8'h00, 32'h00001000,   32'h0,          4'd3},
    '{1'b0, 8'h00, 32'h0,          32'h00000003,   4'd3}   // R3 locked config
  };

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    d = rsp_rdata;
  endtask

  task automatic kwrite(input logic [7:0] a, input logic [31:0] d);
    do_write(8'h1C, KEY);
    do_write(a, d);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 rst_req", {31'b0, rst_req}, 32'h0);
    check("R11 ready", {31'b0, req_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) do_write(VECS[i].addr, VECS[i].data);
      else begin
        do_read(VECS[i].addr, d);
        n_chk++;
        if (d !== VECS[i].exp) begin
          n_fail++;
          $display("FAIL R%0d vector %0d actual=0x%08h expected=0x%08h",
                   VECS[i].req, i, d, VECS[i].exp);
        end
      end
    end

    // R6: enable-always, burst then alternating ticks
    kwrite(8'h20, 32'hFFFF);
    kwrite(8'h08, 32'h0);
    kwrite(8'h00, 32'h1000);
    run_ticks(10);
    do_read(8'h08, d); check("R6 burst", d, 32'd10);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); tick = ~tick;
    end
    @(negedge clk); tick = 1'b0;
    do_read(8'h08, d); check("R6 alternating", d, 32'd14);

    // R6: awake-only enable
    kwrite(8'h00, 32'h2000);
    awake = 1'b0;
    run_ticks(5);
    do_read(8'h08, d); check("R6 asleep holds", d, 32'd14);
    awake = 1'b1;
    run_ticks(5);
    do_read(8'h08, d); check("R6 awake counts", d, 32'd19);
    awake = 1'b0;

    // R9 R10 R8: scale 2, threshold 3, reset enable, auto-zero
    kwrite(8'h00, 32'h0);
    kwrite(8'h08, 32'h0);
    kwrite(8'h20, 32'h3);
    kwrite(8'h00, 32'h1302);
    pulses = 0; doubles = 0;
    run_ticks(30);
    check("R9 pulse count", pulses, 32'd2);
    check("R9 pulse width", doubles, 32'd0);
    check("R8 irq sticky", {31'b0, irq}, 32'h1);
    do_read(8'h08, d); check("R10 auto-zero wrap", d, 32'd4);
    kwrite(8'h08, 32'h0);
    kwrite(8'h00, 32'h0);
    @(negedge clk);
    check("R8 irq cleared", {31'b0, irq}, 32'h0);

    // R9 without reset enable, R10 again
    kwrite(8'h20, 32'h3);
    kwrite(8'h00, 32'h1202);
    pulses = 0;
    run_ticks(30);
    check("R9 no pulse", pulses, 32'd0);
    check("R8 irq set", {31'b0, irq}, 32'h1);
    do_read(8'h08, d); check("R10 count after wraps", d, 32'd4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule